// File: doc/BRIEF.md
# ADC Channel-Group Scan Sequencer

This block drives an external analog-to-digital converter through a small group of adjacent input channels, over and over, for as long as software keeps it running. A single control write sets the run bit, picks one of two channel groups, sets how many channels of the group take part and enables the end-of-scan interrupt. A scan can also be launched by a pulse from a timer or from an external trigger pin. For each channel the block issues a one-cycle start strobe with the channel number. It waits for the converter's done strobe, files the returned result in that channel's data register, and starts the next channel in the same cycle.

When the last channel of the group completes, a sticky end-of-scan flag is set and the scan wraps to the group's first channel. The interrupt line is that flag gated by the enable. Clearing the run bit halts at once. Any conversion in flight is dropped, and the next start always begins from the group's first channel.

Top module: `adc_scan_seq`

## Requirements
- R1: From the halted state, a control write with the start bit set, a `tmr_trig` pulse or an `ext_trig` pulse makes `run` 1 on the next edge. In the following cycle `conv_go` is 1 and `conv_ch` holds the group's first channel.
- R2: The group-select bit chooses the first channel of the group: channel 0 when it is 0, and channel GRP_SZ (4) when it is 1.
- R3: A count field of value n (2 bits) scans n+1 channels, from base to base+n in ascending order. The value 2'b10 scans three channels and 2'b00 scans one. Data registers of channels outside that range are never written.
- R4: A done strobe accepted while running makes `conv_go` 1 in the very next cycle, with no idle cycle between conversions. Successive start strobes are therefore spaced by exactly the converter's turnaround.
- R5: Each accepted result is written into the data register of the channel being converted, and can be read through `rd_ch`/`rd_data`.
- R6: The done strobe of the last channel of the group sets `eos_flag` on the same edge, and the next start strobe goes to the group's first channel.
- R7: `irq` is high exactly while `eos_flag` and the stored interrupt enable are both 1. A write that changes the enable changes `irq` on the next cycle.
- R8: A control write with the start bit 0 clears `run` on that edge. No further `conv_go` is issued until a new start.
- R9: A start after a halt always resumes from the group's first channel, wherever the previous scan stopped.
- R10: Group and count written in the same write that sets start govern the new scan. Group and count written at any time are stored and used by the next scan launched by a trigger.
- R11: A done strobe that arrives after a halt, or in a cycle where `conv_go` is high, is discarded. It writes no data register and does not set the flag.
- R12: `eos_flag` stays set until a `flag_clr` pulse. If a set and a clear fall in the same cycle, the set wins.
- R13: A trigger pulse or a start write while already running does not restart or disturb the scan in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Run bit written by software |
| ctl_grp | input | 1 | Group select written by software |
| ctl_cnt | input | 2 | Channel count field (n+1 channels) |
| ctl_ie | input | 1 | End-of-scan interrupt enable |
| flag_clr | input | 1 | Software clear of the end-of-scan flag |
| tmr_trig | input | 1 | Timer start pulse |
| ext_trig | input | 1 | External start pulse |
| conv_ch | output | 3 | Channel presented to the converter |
| conv_go | output | 1 | One-cycle conversion start strobe |
| conv_done | input | 1 | Converter done strobe |
| conv_res | input | 10 | Converter result, valid with `conv_done` |
| rd_ch | input | 3 | Data register read select |
| rd_data | output | 10 | Data register read value |
| run | output | 1 | Current run bit |
| eos_flag | output | 1 | Sticky end-of-scan flag |
| irq | output | 1 | Interrupt request |

## Verification
Suppose the channel counter or latched group bounds go wrong. The fault shows up on `conv_ch` at the next start strobe, which is at most one converter turnaround after the fault, and as a result filed under the wrong `rd_ch`. A wrong run state shows within one cycle, as a start strobe after a halt or a missing strobe after a done. A bad wrap or flag path shows on `eos_flag` and `irq` at the edge where the last channel's done is taken. The bench therefore logs every start strobe with its cycle stamp. It compares the channel order and the spacing against the converter model's latency, and reads every data register after each scenario.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH    = 8,
  parameter int RES_W  = 10,
  parameter int GRP_SZ = 4,
  localparam int CH_W  = $clog2(NCH),
  localparam int CNT_W = $clog2(GRP_SZ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ctl_start,
  input  logic             ctl_grp,
  input  logic [CNT_W-1:0] ctl_cnt,
  input  logic             ctl_ie,
  input  logic             flag_clr,
  input  logic             tmr_trig,
  input  logic             ext_trig,
  output logic [CH_W-1:0]  conv_ch,
  output logic             conv_go,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_res,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [RES_W-1:0] rd_data,
  output logic             run,
  output logic             eos_flag,
  output logic             irq
);

  logic             grp_q, ie_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0]  base_s, last_s;
  logic [RES_W-1:0] data_q [NCH];

  wire             stop     = ctl_we & ~ctl_start;
  wire             kick     = ~run & ~stop & ((ctl_we & ctl_start) | tmr_trig | ext_trig);
  wire             new_grp  = ctl_we ? ctl_grp : grp_q;
  wire [CNT_W-1:0] new_cnt  = ctl_we ? ctl_cnt : cnt_q;
  wire [CH_W-1:0]  new_base = new_grp ? CH_W'(GRP_SZ) : '0;
  wire             accept   = run & ~stop & conv_done & ~conv_go;
  wire             at_last  = (conv_ch == last_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q   <= 1'b0;
      cnt_q   <= '0;
      ie_q    <= 1'b0;
      run     <= 1'b0;
      conv_go <= 1'b0;
      conv_ch <= '0;
      base_s  <= '0;
      last_s  <= '0;
    end else begin
      if (ctl_we) begin
        grp_q <= ctl_grp;
        cnt_q <= ctl_cnt;
        ie_q  <= ctl_ie;
      end
      conv_go <= 1'b0;
      if (stop) begin
        run <= 1'b0;
      end else if (kick) begin
        run     <= 1'b1;
        base_s  <= new_base;
        last_s  <= new_base + CH_W'(new_cnt);
        conv_ch <= new_base;
        conv_go <= 1'b1;
      end else if (accept) begin
        conv_go <= 1'b1;
        conv_ch <= at_last ? base_s : conv_ch + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      eos_flag <= 1'b0;
    else if (accept && at_last)
      eos_flag <= 1'b1;
    else if (flag_clr)
      eos_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) data_q[i] <= '0;
    end else if (accept) begin
      data_q[conv_ch] <= conv_res;
    end
  end

  assign rd_data = data_q[rd_ch];
  assign irq     = eos_flag & ie_q;

endmodule

module adc_scan_seq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_we,
  input logic            ctl_start,
  input logic            flag_clr,
  input logic            conv_go,
  input logic [CH_W-1:0] conv_ch,
  input logic            conv_done,
  input logic            run,
  input logic            eos_flag,
  input logic            irq,
  input logic            ie_q,
  input logic [CH_W-1:0] base_s,
  input logic [CH_W-1:0] last_s
);

  p_go_in_group_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |-> (conv_ch >= base_s && conv_ch <= last_s));

  p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && conv_done && !conv_go && !(ctl_we && !ctl_start)) |=> conv_go);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && conv_done && !conv_go && !(ctl_we && !ctl_start) && conv_ch == last_s)
      |=> (eos_flag && conv_ch == base_s));

  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_start) |=> (!run && !conv_go));

  p_restart_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (conv_go && conv_ch == base_s));

  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_flag && !flag_clr) |=> eos_flag);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(eos_flag) || $rose(ie_q)));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
  .flag_clr(flag_clr), .conv_go(conv_go), .conv_ch(conv_ch),
  .conv_done(conv_done), .run(run), .eos_flag(eos_flag), .irq(irq),
  .ie_q(ie_q), .base_s(base_s), .last_s(last_s)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int LAT = 4;
  localparam int GAP = LAT + 2;

  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_start = 0, ctl_grp = 0, ctl_ie = 0;
  logic [1:0] ctl_cnt = 0;
  logic flag_clr = 0, tmr_trig = 0, ext_trig = 0;
  logic [2:0] conv_ch, rd_ch = 0, m_ch = 0;
  logic conv_go, conv_done, run, eos_flag, irq;
  logic [9:0] conv_res, rd_data;
  logic [9:0] vals [8];
  int m_cnt;
  int n_tests = 0, n_fail = 0;
  int cyc = 0, go_n = 0;
  int go_log [512];
  int go_cyc [512];

  always #10 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
    .ctl_grp(ctl_grp), .ctl_cnt(ctl_cnt), .ctl_ie(ctl_ie), .flag_clr(flag_clr),
    .tmr_trig(tmr_trig), .ext_trig(ext_trig), .conv_ch(conv_ch), .conv_go(conv_go),
    .conv_done(conv_done), .conv_res(conv_res), .rd_ch(rd_ch), .rd_data(rd_data),
    .run(run), .eos_flag(eos_flag), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0;
      conv_done <= 1'b0;
    end else begin
      conv_done <= (m_cnt == 1) && !conv_go;
      if (conv_go) begin
        m_cnt <= LAT;
        m_ch  <= conv_ch;
      end else if (m_cnt != 0) begin
        m_cnt <= m_cnt - 1;
      end
    end
  end
  assign conv_res = vals[m_ch];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && conv_go && go_n < 512) begin
      go_log[go_n] <= int'(conv_ch);
      go_cyc[go_n] <= cyc;
      go_n <= go_n + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit st, input bit g, input logic [1:0] c, input bit ie);
    @(negedge clk);
    ctl_we = 1; ctl_start = st; ctl_grp = g; ctl_cnt = c; ctl_ie = ie;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic pulse_trig(input bit ext);
    @(negedge clk);
    if (ext) ext_trig = 1; else tmr_trig = 1;
    @(negedge clk);
    ext_trig = 0; tmr_trig = 0;
  endtask

  task automatic chk_data(input string tag, input int ch, input int exp);
    rd_ch = 3'(ch);
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic t_reset();
    chk("reset run", int'(run), 0);
    chk("reset conv_go", int'(conv_go), 0);
    chk("reset eos_flag R12", int'(eos_flag), 0);
    chk("reset irq R7", int'(irq), 0);
    for (int i = 0; i < 8; i++) chk_data("reset data R5", i, 0);
  endtask

  task automatic t_scan3();
    int m;
    vals[0] = 11; vals[1] = 22; vals[2] = 33; vals[3] = 44;
    m = go_n;
    wr(1, 0, 2'b10, 0);
    chk("R1 run after start write", int'(run), 1);
    wait_cyc(3 * GAP - 1);
    chk("R6 flag not early", int'(eos_flag), 0);
    wait_cyc(1);
    chk("R6 flag after third channel", int'(eos_flag), 1);
    chk("R7 irq masked", int'(irq), 0);
    wait_cyc(2);
    chk("R1 R2 first channel group0", go_log[m], 0);
    chk("R3 second channel", go_log[m+1], 1);
    chk("R3 third channel", go_log[m+2], 2);
    chk("R6 wrap to base", go_log[m+3], 0);
    for (int i = 0; i < 3; i++) chk("R4 back-to-back spacing", go_cyc[m+i+1] - go_cyc[m+i], GAP);
    for (int i = 0; i < 3; i++) chk_data("R5 stored result", i, int'(vals[i]));
    chk_data("R3 channel outside count untouched", 3, 0);
    wr(0, 0, 2'b10, 0);
    chk("R8 run cleared", int'(run), 0);
    wait_cyc(1);
    m = go_n;
    wait_cyc(2 * GAP);
    chk("R8 no strobe after halt", go_n, m);
    pulse_clr();
  endtask

  task automatic t_grp1();
    int m;
    for (int i = 4; i < 8; i++) vals[i] = 10'(100 + i);
    m = go_n;
    wr(1, 1, 2'b11, 1);
    wait_cyc(4 * GAP + 2);
    chk("R6 flag group1", int'(eos_flag), 1);
    chk("R7 irq enabled", int'(irq), 1);
    for (int i = 0; i < 4; i++) chk("R2 R3 group1 order", go_log[m+i], 4 + i);
    chk("R6 wrap group1", go_log[m+4], 4);
    for (int i = 4; i < 8; i++) chk_data("R5 group1 data", i, 100 + i);
    wr(0, 1, 2'b11, 1);
    wait_cyc(5);
    chk("R12 flag sticky", int'(eos_flag), 1);
    chk("R7 irq held", int'(irq), 1);
    wr(0, 1, 2'b11, 0);
    chk("R7 irq follows enable", int'(irq), 0);
    chk("R12 flag kept on enable change", int'(eos_flag), 1);
    pulse_clr();
    chk("R12 flag cleared", int'(eos_flag), 0);
  endtask

  task automatic t_single();
    int m;
    vals[0] = 77;
    m = go_n;
    wr(1, 0, 2'b00, 0);
    wait_cyc(2 * GAP + 2);
    chk("R3 single channel", go_log[m], 0);
    chk("R3 single repeats", go_log[m+1], 0);
    chk("R4 single spacing", go_cyc[m+1] - go_cyc[m], GAP);
    chk("R6 flag single", int'(eos_flag), 1);
    chk_data("R5 single data", 0, 77);
    wr(0, 0, 2'b00, 0);
    pulse_clr();
  endtask

  task automatic t_restart();
    int m;
    wr(1, 0, 2'b11, 0);
    wait_cyc(GAP + 3);
    wr(0, 0, 2'b11, 0);
    wait_cyc(1);
    m = go_n;
    wait_cyc(3 * GAP);
    chk("R8 halted mid scan", go_n, m);
    chk("R8 run low", int'(run), 0);
    m = go_n;
    wr(1, 0, 2'b11, 0);
    wait_cyc(2);
    chk("R9 restart at base", go_log[m], 0);
    wr(0, 0, 2'b11, 0);
    pulse_clr();
  endtask

  task automatic t_abort();
    vals[0] = 500;
    wr(1, 0, 2'b00, 0);
    wait_cyc(3);
    wr(0, 0, 2'b00, 0);
    wait_cyc(2 * GAP);
    chk_data("R11 aborted result dropped", 0, 77);
    chk("R11 no flag on abort", int'(eos_flag), 0);
  endtask

  task automatic t_trig();
    int m;
    wr(0, 0, 2'b01, 0);
    m = go_n;
    pulse_trig(0);
    chk("R1 timer trigger starts", int'(run), 1);
    wait_cyc(GAP + 2);
    pulse_trig(1);
    wait_cyc(1);
    wr(1, 0, 2'b01, 0);
    wait_cyc(2 * GAP);
    chk("R1 timer first channel", go_log[m], 0);
    chk("R13 sequence ch1", go_log[m+1], 1);
    chk("R13 sequence wrap", go_log[m+2], 0);
    chk("R13 sequence ch1 again", go_log[m+3], 1);
    for (int i = 0; i < 3; i++) chk("R13 spacing undisturbed", go_cyc[m+i+1] - go_cyc[m+i], GAP);
    wr(0, 1, 2'b01, 0);
    pulse_clr();
    m = go_n;
    pulse_trig(1);
    wait_cyc(GAP + 2);
    chk("R1 external trigger starts", int'(run), 1);
    chk("R10 stored group used by trigger", go_log[m], 4);
    chk("R10 stored count used", go_log[m+1], 5);
    wr(0, 0, 2'b00, 0);
    wait_cyc(1);
    m = go_n;
    wr(1, 1, 2'b10, 0);
    wait_cyc(2);
    chk("R10 settings with start", go_log[m], 4);
    wr(0, 0, 2'b00, 0);
    pulse_clr();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vals[i] = 0;
    wait_cyc(4);
    t_reset();
    rst_n = 1;
    wait_cyc(2);
    t_scan3();
    t_grp1();
    t_single();
    t_restart();
    t_abort();
    t_trig();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule